// File: doc/BRIEF.md
# RTC Digital Trim Accumulator

This block corrects the rate of a 32 kHz real-time clock without touching the oscillator. Software programs a trim word that holds a direction bit and a 5-bit magnitude. On every 16-second strobe the magnitude is added into a small modulo-32 accumulator. Only when that addition wraps past 31 does the block apply a correction, so the average correction per interval is a fraction of the full step, set by the magnitude over 32.

A positive correction is a single-cycle advance strobe. While it is high, the count output shows 128, and the downstream counter chain jumps ahead by that many ticks. A negative correction holds back the corrected tick stream: the next 128 incoming 32 kHz ticks are not passed on. A correction runs to its end before another accumulation is allowed. A 16-second strobe that arrives while a correction is running is held, and it is applied as soon as the correction ends.

There are two resets. The power-on reset clears everything, including the trim word. The ordinary reset clears the accumulator and any running correction but keeps the programmed trim word.

Top module: `rtc_trim_accum`

## Requirements
- R1: The read port returns the trim word as bits [7:6] = 0, bit 5 = direction (0 adds ticks, 1 removes ticks) and bits [4:0] = magnitude. Writing ones to bits [7:6] still reads them back as 0.
- R2: A write takes effect only in a cycle where both regWrEn and wrAllow are 1. A write request with wrAllow = 0 leaves the read value unchanged, and so does wrAllow = 1 with regWrEn = 0.
- R3: porRstN low clears the trim word to 0x00. rstN low keeps the trim word, clears the accumulator to 0 and ends any running correction. After either reset, every output is 0.
- R4: Each accepted 16-second strobe adds the magnitude into a 5-bit accumulator. A carry occurs when the sum exceeds 31, and the sum minus 32 is kept. Starting from 0, n strobes with magnitude m give floor(n*m/32) carries.
- R5: A magnitude of 0 never produces a correction.
- R6: A carry with direction 0 makes advanceStb high for exactly one cycle, the cycle after the strobe, with corrCount = 128 in that cycle. The tick stream is not altered.
- R7: A carry with direction 1 makes retardBusy high from the cycle after the strobe. It stays high until exactly 128 further tickIn pulses have been dropped from tickOut. corrCount starts at 128 and falls by one per dropped tick, then returns to 0.
- R8: Outside a negative correction, tickOut repeats tickIn delayed by one clock.
- R9: A 16-second strobe that arrives during a correction is not lost. Its accumulation runs in the first cycle after the correction ends, and any correction it causes starts in the cycle after that.
- R10: The direction of a running correction is fixed when it starts. Rewriting the direction bit during a negative correction does not stop the ticks from being dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| porRstN | input | 1 | Power-on reset, active low, synchronous; clears the trim word too |
| rstN | input | 1 | Ordinary reset, active low, synchronous; trim word kept |
| tickIn | input | 1 | One-cycle pulse per 32 kHz period |
| sixteenSecStb | input | 1 | One-cycle pulse every 16 seconds |
| regWrEn | input | 1 | Trim word write request |
| wrAllow | input | 1 | Write permission for the trim word |
| regWrData | input | 8 | Trim word write data |
| regRdData | output | 8 | Trim word read data |
| tickOut | output | 1 | Corrected tick stream, one cycle behind tickIn |
| advanceStb | output | 1 | One-cycle request to advance the counter chain |
| retardBusy | output | 1 | High while incoming ticks are being dropped |
| corrCount | output | 8 | 128 during an advance; ticks left to drop during a retard; else 0 |

## Verification
The hardest case to reach is a 16-second strobe that lands inside a running correction. Under real timing a strobe comes once every 16 s, while a correction lasts 128 ticks, so the two almost never overlap. The bench pushes the accumulator to a carry with magnitude 31 and starts a negative correction. It sends a strobe and a direction rewrite partway through the dropped ticks. It then checks that the dropping still finishes at exactly 128 ticks, and that the deferred accumulation produces an advance two cycles later. Fractional carry patterns are covered by a vector table that walks several magnitudes and strobe counts from a cleared accumulator.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

  localparam int DEF_TRIM_W     = 5;
  localparam int DEF_CORR_TICKS = 128;
  localparam int DEF_REG_W      = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADV  = 2'd1,
    ST_RET  = 2'd2
  } corrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accumulate;  // add magnitude into accumulator
    logic loadCnt;     // start a correction: load tick count
    logic clearCnt;    // end of advance: zero the count
    logic countDown;   // one tick dropped
    logic suppress;    // gate incoming ticks
  } ctrlStb_t;

endpackage

// File: rtl/rtc_trim_dp.sv
module rtc_trim_dp
  import rtc_trim_pkg::*;
#(
  parameter int TRIM_W     = DEF_TRIM_W,
  parameter int CORR_TICKS = DEF_CORR_TICKS,
  parameter int REG_W      = DEF_REG_W,
  parameter int CNT_W      = $clog2(CORR_TICKS + 1)
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              regWrEn,
  input  logic              wrAllow,
  input  logic [TRIM_W:0]   wrField,
  input  ctrlStb_t          stb,
  output logic [REG_W-1:0]  regRdData,
  output logic              trimSign,
  output logic              sumCarry,
  output logic              lastTick,
  output logic [CNT_W-1:0]  corrCount,
  output logic              tickOut
);

  localparam int RSV_W = REG_W - TRIM_W - 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CORR_TICKS);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [TRIM_W-1:0] trimMag;
  logic              trimSignQ;
  logic [TRIM_W-1:0] accReg;
  logic [TRIM_W:0]   sumFull;
  logic [CNT_W-1:0]  corrLeft;
  logic              tickQ;
  logic              softRst;

  assign softRst = !porRstN || !rstN;

  // trim word: only the power-on reset touches it
  always_ff @(posedge clk) begin
    if (!porRstN) begin
      trimMag   <= '0;
      trimSignQ <= 1'b0;
    end else if (regWrEn && wrAllow) begin
      trimMag   <= wrField[TRIM_W-1:0];
      trimSignQ <= wrField[TRIM_W];
    end
  end

  assign sumFull  = {1'b0, accReg} + {1'b0, trimMag};
  assign sumCarry = sumFull[TRIM_W];

  always_ff @(posedge clk) begin
    if (softRst)             accReg <= '0;
    else if (stb.accumulate) accReg <= sumFull[TRIM_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (softRst)            corrLeft <= '0;
    else if (stb.loadCnt)   corrLeft <= CNT_LOAD;
    else if (stb.clearCnt)  corrLeft <= '0;
    else if (stb.countDown) corrLeft <= corrLeft - CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (softRst) tickQ <= 1'b0;
    else         tickQ <= tickIn && !stb.suppress;
  end

  assign lastTick  = (corrLeft == CNT_ONE);
  assign corrCount = corrLeft;
  assign tickOut   = tickQ;
  assign trimSign  = trimSignQ;
  assign regRdData = {{RSV_W{1'b0}}, trimSignQ, trimMag};

endmodule

// File: rtl/rtc_trim_ctrl.sv
module rtc_trim_ctrl
  import rtc_trim_pkg::*;
(
  input  logic     clk,
  input  logic     porRstN,
  input  logic     rstN,
  input  logic     sixteenSecStb,
  input  logic     tickIn,
  input  logic     sumCarry,
  input  logic     trimSign,
  input  logic     lastTick,
  output ctrlStb_t stb,
  output logic     advanceStb,
  output logic     retardBusy
);

  corrState_t state, stateNext;
  logic       pendingAcc;
  logic       accNow;
  logic       startCorr;
  logic       softRst;

  assign softRst   = !porRstN || !rstN;
  assign accNow    = (state == ST_IDLE) && (sixteenSecStb || pendingAcc);
  assign startCorr = accNow && sumCarry;

  always_comb begin
    stb.accumulate = accNow;
    stb.loadCnt    = startCorr;
    stb.clearCnt   = (state == ST_ADV);
    stb.countDown  = (state == ST_RET) && tickIn;
    stb.suppress   = (state == ST_RET);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (startCorr) stateNext = trimSign ? ST_RET : ST_ADV;
      ST_ADV:  stateNext = ST_IDLE;
      ST_RET:  if (tickIn && lastTick) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (softRst) state <= ST_IDLE;
    else         state <= stateNext;
  end

  // strobe during a correction is held until it ends
  always_ff @(posedge clk) begin
    if (softRst)                                    pendingAcc <= 1'b0;
    else if (accNow)                                pendingAcc <= 1'b0;
    else if (sixteenSecStb && (state != ST_IDLE))   pendingAcc <= 1'b1;
  end

  assign advanceStb = (state == ST_ADV);
  assign retardBusy = (state == ST_RET);

endmodule

// File: rtl/rtc_trim_accum.sv
module rtc_trim_accum
  import rtc_trim_pkg::*;
#(
  parameter int TRIM_W     = DEF_TRIM_W,
  parameter int CORR_TICKS = DEF_CORR_TICKS,
  parameter int REG_W      = DEF_REG_W,
  parameter int CNT_W      = $clog2(CORR_TICKS + 1)
) (
  input  logic             clk,
  input  logic             porRstN,
  input  logic             rstN,
  input  logic             tickIn,
  input  logic             sixteenSecStb,
  input  logic             regWrEn,
  input  logic             wrAllow,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             tickOut,
  output logic             advanceStb,
  output logic             retardBusy,
  output logic [CNT_W-1:0] corrCount
);

  ctrlStb_t stb;
  logic     trimSign;
  logic     sumCarry;
  logic     lastTick;
  logic     unusedWrBits;

  assign unusedWrBits = ^regWrData[REG_W-1:TRIM_W+1];

  rtc_trim_dp #(
    .TRIM_W    (TRIM_W),
    .CORR_TICKS(CORR_TICKS),
    .REG_W     (REG_W),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk      (clk),
    .porRstN  (porRstN),
    .rstN     (rstN),
    .tickIn   (tickIn),
    .regWrEn  (regWrEn),
    .wrAllow  (wrAllow),
    .wrField  (regWrData[TRIM_W:0]),
    .stb      (stb),
    .regRdData(regRdData),
    .trimSign (trimSign),
    .sumCarry (sumCarry),
    .lastTick (lastTick),
    .corrCount(corrCount),
    .tickOut  (tickOut)
  );

  rtc_trim_ctrl u_ctrl (
    .clk          (clk),
    .porRstN      (porRstN),
    .rstN         (rstN),
    .sixteenSecStb(sixteenSecStb),
    .tickIn       (tickIn),
    .sumCarry     (sumCarry),
    .trimSign     (trimSign),
    .lastTick     (lastTick),
    .stb          (stb),
    .advanceStb   (advanceStb),
    .retardBusy   (retardBusy)
  );

endmodule

// File: rtl/rtc_trim_chk.sv
module rtc_trim_chk #(
  parameter int REG_W = 8,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             porRstN,
  input logic             rstN,
  input logic             tickIn,
  input logic             sixteenSecStb,
  input logic             regWrEn,
  input logic             wrAllow,
  input logic [REG_W-1:0] regRdData,
  input logic             tickOut,
  input logic             advanceStb,
  input logic             retardBusy,
  input logic [CNT_W-1:0] corrCount
);

  // R2
  wr_block_chk: assert property (@(posedge clk) disable iff (!porRstN || !rstN)
    !(regWrEn && wrAllow) |=> $stable(regRdData));

  // R5
  zero_mag_chk: assert property (@(posedge clk) disable iff (!porRstN || !rstN)
    (regRdData[4:0] == 5'd0 && sixteenSecStb && !retardBusy && !advanceStb)
      |=> (!advanceStb && !retardBusy));

  // R6
  adv_single_chk: assert property (@(posedge clk) disable iff (!porRstN || !rstN)
    advanceStb |=> !advanceStb);

  // R7
  ret_drop_chk: assert property (@(posedge clk) disable iff (!porRstN || !rstN)
    (retardBusy && tickIn) |=> !tickOut);

  // R7
  ret_count_chk: assert property (@(posedge clk) disable iff (!porRstN || !rstN)
    (retardBusy && tickIn && corrCount > CNT_W'(1))
      |=> (corrCount == $past(corrCount) - CNT_W'(1)));

  // R8
  tick_pass_chk: assert property (@(posedge clk) disable iff (!porRstN || !rstN)
    (!retardBusy && tickIn) |=> tickOut);

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!porRstN || !rstN)
    !(advanceStb && retardBusy));

endmodule

bind rtc_trim_accum rtc_trim_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/rtc_trim_accum_tb.sv
`timescale 1ns/1ps
module rtc_trim_accum_tb;

  logic       clk = 1'b0;
  logic       porRstN = 1'b0;
  logic       rstN = 1'b0;
  logic       tickIn = 1'b0;
  logic       sixteenSecStb = 1'b0;
  logic       regWrEn = 1'b0;
  logic       wrAllow = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       tickOut;
  logic       advanceStb;
  logic       retardBusy;
  logic [7:0] corrCount;

  int testCnt = 0;
  int failCnt = 0;
  int cyc = 0;

  // output monitor counts (sampled at negedge)
  int tickOutTot = 0;
  int advTot = 0;
  int retStartTot = 0;
  int advBadTot = 0;
  logic prevBusy = 1'b0;

  always #2.5 clk = ~clk;

  rtc_trim_accum u_dut (
    .clk(clk), .porRstN(porRstN), .rstN(rstN), .tickIn(tickIn),
    .sixteenSecStb(sixteenSecStb), .regWrEn(regWrEn), .wrAllow(wrAllow),
    .regWrData(regWrData), .regRdData(regRdData), .tickOut(tickOut),
    .advanceStb(advanceStb), .retardBusy(retardBusy), .corrCount(corrCount)
  );

  always @(negedge clk) begin
    if (tickOut) tickOutTot++;
    if (advanceStb) advTot++;
    if (advanceStb && corrCount != 8'd128) advBadTot++;
    if (retardBusy && !prevBusy) retStartTot++;
    prevBusy = retardBusy;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", testCnt + 1, failCnt + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chkEq(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic sendStrobe();
    @(negedge clk) sixteenSecStb = 1'b1;
    @(negedge clk) sixteenSecStb = 1'b0;
  endtask

  task automatic sendTick();
    @(negedge clk) tickIn = 1'b1;
    @(negedge clk) tickIn = 1'b0;
  endtask

  task automatic writeTrim(input logic [7:0] val, input logic allow);
    @(negedge clk) begin regWrEn = 1'b1; wrAllow = allow; regWrData = val; end
    @(negedge clk) begin regWrEn = 1'b0; wrAllow = 1'b0; end
  endtask

  task automatic softReset();
    @(negedge clk) rstN = 1'b0;
    @(negedge clk) rstN = 1'b1;
  endtask

  typedef struct packed {
    logic [4:0] mag;
    logic       sgn;
    logic [7:0] nStb;
    logic [7:0] expCarry;
  } vec_t;

  // R4 vectors: carries = floor(nStb*mag/32) from a cleared accumulator
  localparam vec_t VECS [6] = '{
    '{mag: 5'd1,  sgn: 1'b0, nStb: 8'd40, expCarry: 8'd1},
    '{mag: 5'd31, sgn: 1'b0, nStb: 8'd32, expCarry: 8'd31},
    '{mag: 5'd16, sgn: 1'b0, nStb: 8'd10, expCarry: 8'd5},
    '{mag: 5'd5,  sgn: 1'b1, nStb: 8'd13, expCarry: 8'd2},
    '{mag: 5'd0,  sgn: 1'b0, nStb: 8'd20, expCarry: 8'd0},
    '{mag: 5'd7,  sgn: 1'b1, nStb: 8'd9,  expCarry: 8'd1}
  };

  initial begin
    int t0, a0, r0, b0, sent, outBefore;
    repeat (3) @(negedge clk);
    porRstN = 1'b1; rstN = 1'b1;
    @(negedge clk);

    // R3 reset state
    chkEq("R3 por trim", regRdData, 0);
    chkEq("R3 por adv", advanceStb, 0);
    chkEq("R3 por busy", retardBusy, 0);
    chkEq("R3 por count", corrCount, 0);
    chkEq("R3 por tick", tickOut, 0);

    // R1 reserved bits read 0
    writeTrim(8'hFF, 1'b1);
    chkEq("R1 readback", regRdData, 8'h3F);

    // R2 blocked writes
    writeTrim(8'h00, 1'b0);
    chkEq("R2 wrAllow=0", regRdData, 8'h3F);
    @(negedge clk) begin regWrEn = 1'b0; wrAllow = 1'b1; regWrData = 8'h00; end
    @(negedge clk) wrAllow = 1'b0;
    chkEq("R2 regWrEn=0", regRdData, 8'h3F);

    // R3 ordinary reset keeps trim, power-on reset clears it
    softReset();
    chkEq("R3 soft keeps", regRdData, 8'h3F);
    @(negedge clk) porRstN = 1'b0;
    @(negedge clk) porRstN = 1'b1;
    chkEq("R3 por clears", regRdData, 0);

    // R3 ordinary reset clears the accumulator
    writeTrim(8'h10, 1'b1);
    a0 = advTot;
    sendStrobe();
    softReset();
    sendStrobe();
    @(negedge clk);
    chkEq("R3 acc cleared", advTot - a0, 0);
    sendStrobe();
    @(negedge clk);
    chkEq("R3 acc carry", advTot - a0, 1);

    // R4/R5 vector table
    foreach (VECS[i]) begin
      softReset();
      writeTrim({2'b00, VECS[i].sgn, VECS[i].mag}, 1'b1);
      t0 = tickOutTot; a0 = advTot; r0 = retStartTot; b0 = advBadTot;
      sent = 0;
      for (int s = 0; s < int'(VECS[i].nStb); s++) begin
        sendStrobe();
        if (VECS[i].sgn) begin
          repeat (129) sendTick();
          sent += 129;
        end else begin
          repeat (2) sendTick();
          sent += 2;
        end
      end
      repeat (3) @(negedge clk);
      if (VECS[i].sgn) begin
        chkEq($sformatf("R4 vec%0d retard starts", i), retStartTot - r0, int'(VECS[i].expCarry));
        chkEq($sformatf("R7 vec%0d ticks out", i), tickOutTot - t0,
              sent - 128 * int'(VECS[i].expCarry));
        chkEq($sformatf("R4 vec%0d no adv", i), advTot - a0, 0);
      end else begin
        chkEq($sformatf("R4 vec%0d adv pulses", i), advTot - a0, int'(VECS[i].expCarry));
        chkEq($sformatf("R6 vec%0d ticks out", i), tickOutTot - t0, sent);
        chkEq($sformatf("R6 vec%0d adv count", i), advBadTot - b0, 0);
      end
      if (VECS[i].mag == 5'd0)
        chkEq("R5 zero magnitude", (advTot - a0) + (retStartTot - r0), 0);
    end

    // R6 advance timing
    softReset();
    writeTrim(8'h1F, 1'b1);
    sendStrobe();
    chkEq("R6 no carry first", advanceStb, 0);
    sendStrobe();
    chkEq("R6 adv high", advanceStb, 1);
    chkEq("R6 adv count", corrCount, 128);
    @(negedge clk);
    chkEq("R6 adv one cycle", advanceStb, 0);
    chkEq("R6 count cleared", corrCount, 0);

    // R8 tick passthrough
    sendTick();
    chkEq("R8 tick passes", tickOut, 1);
    @(negedge clk);
    chkEq("R8 tick one cycle", tickOut, 0);

    // R7 retard: acc from 0, mag 31 direction 1
    softReset();
    writeTrim(8'h3F, 1'b1);
    sendStrobe();
    sendStrobe();
    chkEq("R7 busy start", retardBusy, 1);
    chkEq("R7 count start", corrCount, 128);
    sendTick();
    chkEq("R7 tick dropped", tickOut, 0);
    chkEq("R7 count 127", corrCount, 127);
    repeat (126) sendTick();
    chkEq("R7 still busy", retardBusy, 1);
    chkEq("R7 count 1", corrCount, 1);
    sendTick();
    chkEq("R7 last dropped", tickOut, 0);
    chkEq("R7 busy end", retardBusy, 0);
    chkEq("R7 count zero", corrCount, 0);
    sendTick();
    chkEq("R7 tick after", tickOut, 1);

    // R9/R10: acc is 30; next strobe gives 61 -> carry, retard
    sendStrobe();
    chkEq("R9 retard again", retardBusy, 1);
    repeat (10) sendTick();
    a0 = advTot;
    sendStrobe();          // deferred
    writeTrim(8'h1F, 1'b1); // direction to 0 mid-correction
    outBefore = tickOutTot;
    repeat (118) sendTick();
    chkEq("R10 ticks still dropped", tickOutTot - outBefore, 0);
    chkEq("R10 no adv during", advTot - a0, 0);
    chkEq("R9 busy done", retardBusy, 0);
    @(negedge clk);
    chkEq("R9 deferred adv", advanceStb, 1);
    chkEq("R9 deferred count", corrCount, 128);
    @(negedge clk);
    chkEq("R9 adv over", advanceStb, 0);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule